// File: doc/BRIEF.md
# Package Deep Power-Down Sequencer

This controller moves a two-thread processor package into its deepest power-saving state and back out again. Entry is gated on two conditions holding together: every thread has reported deep idle, and the L2 cache has been shrunk to zero active ways. A thread reports deep idle through either of two paths, a monitor/wait-style hint or a read of a level-6 I/O address. Both paths set the same per-thread status bit. Once entry is gated, the sequencer asks the on-die state SRAM to save the architectural state. Only after the save completes does it drop the core-voltage target to retention level and stop the PLLs. While the package sits in that state it is exempt from snooping.

The chipset controls the exit through four active-low sideband pins. It first asserts all four, then releases them in a fixed order: deeper-stop, deep-sleep, sleep, stop-clock. Releasing deep-sleep ramps the voltage target to the lowest-frequency level and enables the PLLs. Releasing sleep produces a core reset pulse of programmable length, followed by a restore handshake with the SRAM. The package is declared running again only when the restore is done and stop-clock has been released. A release out of order freezes the sequence and sets a sticky error flag. A thread waking during the save aborts entry without any restore.

Top module: `pdseq_top`

## Requirements
- R1: The save request rises in the cycle after an edge at which every thread's idle bit is set, `l2_ways_i` is zero and no wake is present. Otherwise the sequencer stays running.
- R2: A thread's idle bit is set by either `mwait_hint_i` or `lvl6_rd_i` on that thread. It is cleared by `thr_wake_i` on that thread and by the core reset pulse.
- R3: `vtgt_o` stays at nominal (2'b00) while `save_req_o` is high. It changes to retention (2'b01) only in the cycle after `save_done_i` is seen. At that point the save request drops and `pll_en_o` goes low.
- R4: A wake on any thread while the save is pending returns the sequencer to running in the next cycle, even if `save_done_i` is high in the same cycle. The voltage target stays nominal and no restore is requested.
- R5: `snoop_free_o` is high from the voltage drop until the sleep release. `deeper_stop_ni` is the first pin that may be released.
- R6: Releasing `deep_sleep_ni` after `deeper_stop_ni` sets `vtgt_o` to the lowest-frequency level (2'b10) and raises `pll_en_o` in the next cycle.
- R7: Releasing `sleep_ni` next holds `core_rst_o` high for exactly RST_CYC cycles (default 16). `restore_req_o` then rises and stays high until `restore_done_i`.
- R8: `running_o` returns high only after `restore_done_i` has been seen and `stop_clk_ni` is high. `running_o` is high out of reset.
- R9: A pin released ahead of its turn holds the exit sequence where it is and sets `seq_err_o`. The flag stays set until reset.
- R10: After the voltage drop, release tracking starts only once all four sideband pins are low. Pins that are still high before that point raise no error and cause no advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mwait_hint_i | input | NUM_THR | Per-thread deep-idle hint from a monitor/wait instruction |
| lvl6_rd_i | input | NUM_THR | Per-thread level-6 I/O read strobe |
| thr_wake_i | input | NUM_THR | Per-thread exit from deep idle |
| l2_ways_i | input | WAY_W | Currently active L2 ways |
| save_done_i | input | 1 | State SRAM save complete |
| restore_done_i | input | 1 | State SRAM restore complete |
| deeper_stop_ni | input | 1 | Sideband deeper-stop, active low |
| deep_sleep_ni | input | 1 | Sideband deep-sleep, active low |
| sleep_ni | input | 1 | Sideband sleep, active low |
| stop_clk_ni | input | 1 | Sideband stop-clock, active low |
| save_req_o | output | 1 | State save request |
| restore_req_o | output | 1 | State restore request |
| vtgt_o | output | 2 | Voltage target: 00 nominal, 01 retention, 10 low-frequency |
| pll_en_o | output | 1 | PLL enable |
| core_rst_o | output | 1 | Core reset pulse |
| snoop_free_o | output | 1 | Package needs no snoop response |
| running_o | output | 1 | Package in the running state |
| seq_err_o | output | 1 | Sticky out-of-order release flag |

## Verification
The assertions assume that the SRAM raises `save_done_i` and `restore_done_i` only while the matching request is high. They also assume the chipset asserts all four sideband pins before it starts releasing any of them. The stimulus meets both assumptions: done strobes are driven only in cycles where the request is visible, and every exit pass drives all four pins low before the first release. Out-of-order releases are applied on purpose, to exercise the error hold. Wake and save-done are driven in the same cycle, to exercise abort priority.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [3:0] {
    ST_RUN, ST_SAVE, ST_ARM, ST_W_VREL, ST_W_PLL, ST_W_RST,
    ST_RST, ST_RESTORE, ST_W_CLK
  } seq_st_e;

  typedef enum logic [1:0] {
    VT_NOM = 2'b00,
    VT_RET = 2'b01,
    VT_LFM = 2'b10
  } vtgt_e;

  localparam int unsigned NUM_PINS = 4;
endpackage

// File: rtl/pdseq_idle_track.sv
module pdseq_idle_track #(
  parameter int unsigned NUM_THR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] mwait_hint_i,
  input  logic [NUM_THR-1:0] lvl6_rd_i,
  input  logic [NUM_THR-1:0] thr_wake_i,
  input  logic               clr_i,
  output logic               all_idle_o,
  output logic               leave_o
);
  logic [NUM_THR-1:0] idle_q;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             idle_q[t] <= 1'b0;
      else if (clr_i || thr_wake_i[t])        idle_q[t] <= 1'b0;
      else if (mwait_hint_i[t] || lvl6_rd_i[t]) idle_q[t] <= 1'b1;
    end

    AST_IDLE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mwait_hint_i[t] || lvl6_rd_i[t]) && !$past(thr_wake_i[t]) && !$past(clr_i))
      |-> idle_q[t]); // R2
  end

  assign all_idle_o = &idle_q;
  // a wake this cycle counts as leaving, so abort is not delayed a cycle
  assign leave_o    = (|thr_wake_i) || !(&idle_q);
endmodule

// File: rtl/pdseq_rst_timer.sv
module pdseq_rst_timer #(
  parameter int unsigned RST_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CNT_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RST_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R7
endmodule

// File: rtl/pdseq_order_chk.sv
module pdseq_order_chk
  import pdseq_pkg::*;
(
  input  logic [NUM_PINS-1:0] rel_i,   // 1 = released, index = release order
  input  logic [1:0]          stage_i, // pin expected next
  input  logic                en_i,
  output logic                adv_o,
  output logic                err_o
);
  logic early;

  always_comb begin
    early = 1'b0;
    for (int k = 0; k < NUM_PINS; k++)
      if (k > int'(stage_i) && rel_i[k]) early = 1'b1;
  end

  assign err_o = en_i && early;
  assign adv_o = en_i && !early && rel_i[stage_i];
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int unsigned NUM_THR = 2,
  parameter int unsigned WAY_W   = 4,
  parameter int unsigned RST_CYC = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_THR-1:0] mwait_hint_i,
  input  logic [NUM_THR-1:0] lvl6_rd_i,
  input  logic [NUM_THR-1:0] thr_wake_i,
  input  logic [WAY_W-1:0]   l2_ways_i,
  input  logic               save_done_i,
  input  logic               restore_done_i,
  input  logic               deeper_stop_ni,
  input  logic               deep_sleep_ni,
  input  logic               sleep_ni,
  input  logic               stop_clk_ni,
  output logic               save_req_o,
  output logic               restore_req_o,
  output logic [1:0]         vtgt_o,
  output logic               pll_en_o,
  output logic               core_rst_o,
  output logic               snoop_free_o,
  output logic               running_o,
  output logic               seq_err_o
);
  seq_st_e st_q, st_d;
  logic    all_idle, leave, rst_done, adv, err, chk_en, entry_ok, err_q;
  logic [1:0] stage;
  logic [NUM_PINS-1:0] rel;

  assign rel = {stop_clk_ni, sleep_ni, deep_sleep_ni, deeper_stop_ni};

  pdseq_idle_track #(.NUM_THR(NUM_THR)) i_idle (
    .clk_i, .rst_ni, .mwait_hint_i, .lvl6_rd_i, .thr_wake_i,
    .clr_i(core_rst_o), .all_idle_o(all_idle), .leave_o(leave)
  );

  pdseq_rst_timer #(.RST_CYC(RST_CYC)) i_tmr (
    .clk_i, .rst_ni, .run_i(st_q == ST_RST), .done_o(rst_done)
  );

  always_comb begin
    chk_en = 1'b1;
    unique case (st_q)
      ST_W_VREL: stage = 2'd0;
      ST_W_PLL:  stage = 2'd1;
      ST_W_RST:  stage = 2'd2;
      ST_RST, ST_RESTORE, ST_W_CLK: stage = 2'd3;
      default: begin stage = 2'd3; chk_en = 1'b0; end
    endcase
  end

  pdseq_order_chk i_ord (.rel_i(rel), .stage_i(stage), .en_i(chk_en),
                         .adv_o(adv), .err_o(err));

  assign entry_ok = all_idle && (l2_ways_i == '0) && !(|thr_wake_i);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:     if (entry_ok) st_d = ST_SAVE;
      ST_SAVE:    if (leave) st_d = ST_RUN;
                  else if (save_done_i) st_d = ST_ARM;
      ST_ARM:     if (rel == '0) st_d = ST_W_VREL;
      ST_W_VREL:  if (adv) st_d = ST_W_PLL;
      ST_W_PLL:   if (adv) st_d = ST_W_RST;
      ST_W_RST:   if (adv) st_d = ST_RST;
      ST_RST:     if (rst_done) st_d = ST_RESTORE;
      ST_RESTORE: if (restore_done_i) st_d = ST_W_CLK;
      ST_W_CLK:   if (adv) st_d = ST_RUN;
      default:    st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_RUN;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      err_q <= err_q | err;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_RUN, ST_SAVE:            vtgt_o = VT_NOM;
      ST_ARM, ST_W_VREL, ST_W_PLL: vtgt_o = VT_RET;
      default:                    vtgt_o = VT_LFM;
    endcase
  end

  assign save_req_o    = (st_q == ST_SAVE);
  assign restore_req_o = (st_q == ST_RESTORE);
  assign core_rst_o    = (st_q == ST_RST);
  assign pll_en_o      = (vtgt_o != VT_RET);
  assign snoop_free_o  = (st_q inside {ST_ARM, ST_W_VREL, ST_W_PLL, ST_W_RST});
  assign running_o     = (st_q == ST_RUN);
  assign seq_err_o     = err_q;

  AST_ENTRY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(save_req_o) && $past(running_o)) |-> $past(entry_ok)); // R1
  AST_VDROP_AFTER_SAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vtgt_o == VT_RET && $past(vtgt_o) == VT_NOM) |-> $past(save_done_i)); // R3
  AST_NO_RESTORE_ON_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(save_req_o) && running_o) |-> !restore_req_o); // R4
  AST_PLL_AT_LFM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pll_en_o) |-> (vtgt_o == VT_LFM)); // R6
  AST_RESTORE_AFTER_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(restore_req_o) |-> $past(core_rst_o)); // R7
  AST_RUN_AFTER_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> ($past(st_q) == ST_W_CLK || $past(st_q) == ST_SAVE)); // R8
  AST_HOLD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err |=> (st_q == $past(st_q))); // R9
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(seq_err_o) |-> seq_err_o); // R9
  AST_ARM_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == ST_ARM && $past(rel) != '0) |-> (st_q == ST_ARM && !$rose(seq_err_o))); // R10
endmodule

// File: tb/test_pdseq_top.sv
module test_pdseq_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] mw = '0, l6 = '0, wk = '0;
  logic [3:0] l2 = '0;
  logic sd = 1'b0, rd = 1'b0;
  logic [3:0] pins = 4'hF; // {stop_clk, sleep, deep_sleep, deeper_stop}
  logic save_req, restore_req, pll_en, core_rst, snoop_free, running, seq_err;
  logic [1:0] vtgt;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pdseq_top i_pdseq_top (
    .clk_i(clk), .rst_ni, .mwait_hint_i(mw), .lvl6_rd_i(l6), .thr_wake_i(wk),
    .l2_ways_i(l2), .save_done_i(sd), .restore_done_i(rd),
    .deeper_stop_ni(pins[0]), .deep_sleep_ni(pins[1]), .sleep_ni(pins[2]),
    .stop_clk_ni(pins[3]), .save_req_o(save_req), .restore_req_o(restore_req),
    .vtgt_o(vtgt), .pll_en_o(pll_en), .core_rst_o(core_rst),
    .snoop_free_o(snoop_free), .running_o(running), .seq_err_o(seq_err)
  );

  // {save_req, restore_req, vtgt[1:0], pll_en, core_rst, snoop_free, running, seq_err}
  localparam logic [8:0] E_RUN  = 9'b0_0_00_1_0_0_1_0;
  localparam logic [8:0] E_SAVE = 9'b1_0_00_1_0_0_0_0;
  localparam logic [8:0] E_DEEP = 9'b0_0_01_0_0_1_0_0;
  localparam logic [8:0] E_LFM  = 9'b0_0_10_1_0_1_0_0;
  localparam logic [8:0] E_RST  = 9'b0_0_10_1_1_0_0_0;
  localparam logic [8:0] E_REST = 9'b0_1_10_1_0_0_0_0;
  localparam logic [8:0] E_WCLK = 9'b0_0_10_1_0_0_0_0;

  typedef struct packed {
    logic [1:0] mw; logic [1:0] l6; logic [1:0] wk; logic [3:0] l2;
    logic sd; logic rd; logic [3:0] pins; logic [8:0] exp; logic [3:0] req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{2'b01, 2'b00, 2'b00, 4'h3, 1'b0, 1'b0, 4'hF, E_RUN,  4'd2},  // R2 hint path
    '{2'b00, 2'b10, 2'b00, 4'h3, 1'b0, 1'b0, 4'hF, E_RUN,  4'd2},  // R2 I/O path
    '{2'b00, 2'b00, 2'b00, 4'h3, 1'b0, 1'b0, 4'hF, E_RUN,  4'd1},  // R1 ways nonzero
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF, E_SAVE, 4'd1},  // R1 gate open
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF, E_SAVE, 4'd3},  // R3 waits for done
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 4'hF, E_DEEP, 4'd3},  // R3 drop
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF, E_DEEP, 4'd10}, // R10
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h1, E_DEEP, 4'd10}, // R10 not armed
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h0, E_DEEP, 4'd5},  // R5 armed
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h1, E_DEEP, 4'd5},  // R5 deeper-stop
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h3, E_LFM,  4'd6},  // R6 deep-sleep
    '{2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h7, E_RST,  4'd7}   // R7 sleep
  };

  function automatic logic [8:0] obs();
    return {save_req, restore_req, vtgt, pll_en, core_rst, snoop_free, running, seq_err};
  endfunction

  task automatic chk(input logic [8:0] exp, input string tag);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, obs(), exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %b exp %b", tag, act, exp);
    end
  endtask

  // drive at negedge, sample one ns after the next posedge
  task automatic step(input logic [1:0] m, input logic [1:0] l, input logic [1:0] w,
                      input logic [3:0] ways, input logic s, input logic r,
                      input logic [3:0] p);
    @(negedge clk);
    mw = m; l6 = l; wk = w; l2 = ways; sd = s; rd = r; pins = p;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog got hang exp finish");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(posedge clk); #1;
    chk(E_RUN, "reset R8");
    @(negedge clk); rst_ni = 1'b1;

    foreach (VEC[i]) begin
      step(VEC[i].mw, VEC[i].l6, VEC[i].wk, VEC[i].l2, VEC[i].sd, VEC[i].rd, VEC[i].pins);
      chk(VEC[i].exp, $sformatf("vec%0d R%0d", i, VEC[i].req));
    end

    // R7 reset pulse length then restore request
    n = 1;
    for (int k = 0; k < 40 && core_rst; k++) begin
      step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h7);
      if (core_rst) n++;
    end
    checks++;
    if (n != 16) begin errors++; $display("FAIL R7 reset cycles got %0d exp 16", n); end
    chk(E_REST, "R7 restore req");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h7);
    chk(E_REST, "R7 restore held");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b1, 4'h7);
    chk(E_WCLK, "R8 not running before stop-clock");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    chk(E_RUN, "R8 running");

    // R4 abort: wake with save_done in the same cycle
    step(2'b11, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    chk(E_RUN, "R2 idle set");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    chk(E_SAVE, "R1 entry");
    step(2'b00, 2'b00, 2'b01, 4'h0, 1'b1, 1'b0, 4'hF);
    chk(E_RUN, "R4 abort");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    chk(E_RUN, "R4 no re-entry, R2 wake cleared");

    // R9 out-of-order release
    step(2'b01, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'hF);
    chk(E_SAVE, "R1 re-entry");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b1, 1'b0, 4'hF);
    chk(E_DEEP, "R3 drop");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h0);
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h4);
    chk(E_DEEP | 9'b1, "R9 early sleep holds");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h5);
    chk(E_DEEP | 9'b1, "R9 still held");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h1);
    chk_bit(seq_err, 1'b1, "R9 sticky");
    step(2'b00, 2'b00, 2'b00, 4'h0, 1'b0, 1'b0, 4'h3);
    chk(E_LFM | 9'b1, "R9 resumes R6");
    finish_run();
  end
endmodule